// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic stage of a small 8-bit processor core. Each cycle it takes an operation code, a destination operand, a source operand (register value or immediate) and a bit index. It produces an 8-bit result combinationally from those inputs and from the flag word it holds. The operations are add and subtract with and without carry, compare, chained compare, AND, OR, XOR, one's and two's complement, increment, decrement, shifts, rotates through carry and nibble swap. There are also single-bit operations on the flag word and on the T flag.

The next flag word is shown combinationally on `flags_next`. It is written into the internal flag register on the rising clock edge when `exec` is high. The registered word on `flags` then becomes the carry and T source for the following operation. Chains of add-with-carry, subtract-with-carry and compare-with-carry can therefore run over several bytes, one byte per cycle.

The flag word is ordered, from bit 7 down to bit 0: I (global enable), T (bit store), H (half carry), S (signed test), V (overflow), N (negative), Z (zero), C (carry). Operation codes are 5 bits wide. Codes 23 to 31 are unused.

Top module: `alu8_flags`

## Requirements
- R1: Op 0 gives a+b and op 1 gives a+b+C. Op 2 and op 4 give a-b, and op 3 and op 5 give a-b-C. Ops 4 and 5 are compares whose result also carries that difference. All six write Z, C, N, V and H.
- R2: For add, C is the carry out of bit 7 and H is the carry from bit 3 into bit 4. For subtract and compare, C is the borrow out of bit 7 and H is the borrow from bit 4 into bit 3. V is set when the signed result does not fit in 8 bits.
- R3: For op 3 and op 5, Z is cleared when the result is nonzero and otherwise keeps its previous value, so a zero result can never set Z.
- R4: Op 6 (AND), op 7 (OR) and op 8 (XOR) write Z and N and clear V, and leave C and H unchanged.
- R5: Op 11 gives a+1 and op 12 gives a-1. Both write Z and N, and both leave C and H unchanged. V is set only on 0x7F to 0x80 for increment and only on 0x80 to 0x7F for decrement.
- R6: Op 9 gives 0xFF-a and sets C to 1 and V to 0. Op 10 gives 0x00-a, with C, H and V following the subtract rules of R2 with zero as the minuend.
- R7: Op 13 shifts left with 0 in. Op 14 shifts right with 0 in. Op 15 rotates left through C. Op 16 rotates right through C. Op 17 shifts right keeping bit 7. The bit shifted out goes to C, V becomes N XOR C, Z and N follow the result, and H is unchanged.
- R8: Op 18 exchanges bits 3:0 with bits 7:4 and changes no flag.
- R9: Every operation that writes N or V also sets S to N XOR V. Every other operation keeps S.
- R10: Op 19 sets flag bit `bit_idx` and op 20 clears it, using the bit order I,T,H,S,V,N,Z,C from 7 to 0. Op 21 copies a[bit_idx] into T. Op 22 returns a with bit `bit_idx` replaced by T. These four ops return a unchanged apart from that bit, and change no other flag.
- R11: Ops 23 to 31 return a and change no flag.
- R12: The flag register clears to 0x00 on reset. It loads `flags_next` on the rising edge only when `exec` is 1, and holds otherwise.
- R13: `result` and `flags_next` follow the inputs and the registered flags in the same cycle, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec | input | 1 | Commit `flags_next` into the flag register on this edge |
| op | input | 5 | Operation code |
| opd_a | input | DW | Destination operand |
| opd_b | input | DW | Source operand or immediate |
| bit_idx | input | 3 | Bit index for flag set/clear, bit store and bit load |
| result | output | DW | Combinational result |
| flags_next | output | 8 | Flag word that the current operation would write |
| flags | output | 8 | Registered flag word |

## Verification
The bench builds the block with its default operand width of 8. At that width the half-carry boundary between bits 3 and 4, the signed overflow edges at 0x7F/0x80 and the carry-out at 0xFF all fall on the operand corners 0x00, 0x7F, 0x80 and 0xFF. Every operation is run on every pair of those corners with a carry in of 0 and of 1, after the flag word has been preloaded through the set and clear ops, so the chained-zero rule sees Z both set and clear. Long random runs with `exec` sometimes low then mix flag states and operations across cycles.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec,
  input  logic [4:0]    op,
  input  logic [DW-1:0] opd_a,
  input  logic [DW-1:0] opd_b,
  input  logic [2:0]    bit_idx,
  output logic [DW-1:0] result,
  output logic [7:0]    flags_next,
  output logic [7:0]    flags
);
  localparam int MSB = DW - 1;
  localparam int HB  = DW / 2;
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] SMAX = ~SMIN;

  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FH = 5, FT = 6, FI = 7;

  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_CP  = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7;
  localparam logic [4:0] OP_XOR = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11;
  localparam logic [4:0] OP_DEC = 5'd12, OP_LSL = 5'd13, OP_LSR = 5'd14, OP_ROL = 5'd15;
  localparam logic [4:0] OP_ROR = 5'd16, OP_ASR = 5'd17, OP_SWP = 5'd18, OP_FSET = 5'd19;
  localparam logic [4:0] OP_FCLR = 5'd20, OP_BST = 5'd21, OP_BLD = 5'd22;

  logic [7:0] flg_q;
  logic       cin;
  assign cin = flg_q[FC];

  logic          add_c, sub_c, chain_op;
  logic [DW-1:0] sx, sy;
  logic [DW:0]   sum_w, diff_w;
  logic          add_h, sub_h, add_v, sub_v;

  assign chain_op = (op == OP_SBC) || (op == OP_CPC);
  assign add_c    = (op == OP_ADC) & cin;
  assign sub_c    = chain_op & cin;
  assign sx       = (op == OP_NEG) ? '0 : opd_a;
  assign sy       = (op == OP_NEG) ? opd_a : opd_b;

  assign sum_w  = {1'b0, opd_a} + {1'b0, opd_b} + {{DW{1'b0}}, add_c};
  assign diff_w = {1'b0, sx} - {1'b0, sy} - {{DW{1'b0}}, sub_c};

  assign add_h = opd_a[HB] ^ opd_b[HB] ^ sum_w[HB];
  assign sub_h = sx[HB] ^ sy[HB] ^ diff_w[HB];
  assign add_v = (opd_a[MSB] == opd_b[MSB]) & (sum_w[MSB] != opd_a[MSB]);
  assign sub_v = (sx[MSB] != sy[MSB]) & (diff_w[MSB] != sx[MSB]);

  logic [DW-1:0] res;
  logic c_n, z_n, n_n, v_n, s_n, h_n, t_n;
  logic upd, shv;
  logic [7:0] nxt;

  always_comb begin
    res = opd_a;
    c_n = flg_q[FC];
    h_n = flg_q[FH];
    v_n = flg_q[FV];
    t_n = flg_q[FT];
    upd = 1'b0;
    shv = 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin
        res = sum_w[MSB:0]; c_n = sum_w[DW]; h_n = add_h; v_n = add_v; upd = 1'b1;
      end
      OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
        res = diff_w[MSB:0]; c_n = diff_w[DW]; h_n = sub_h; v_n = sub_v; upd = 1'b1;
      end
      OP_AND: begin res = opd_a & opd_b; v_n = 1'b0; upd = 1'b1; end
      OP_OR:  begin res = opd_a | opd_b; v_n = 1'b0; upd = 1'b1; end
      OP_XOR: begin res = opd_a ^ opd_b; v_n = 1'b0; upd = 1'b1; end
      OP_COM: begin res = ~opd_a; c_n = 1'b1; v_n = 1'b0; upd = 1'b1; end
      OP_INC: begin res = opd_a + DW'(1); v_n = (opd_a == SMAX); upd = 1'b1; end
      OP_DEC: begin res = opd_a - DW'(1); v_n = (opd_a == SMIN); upd = 1'b1; end
      OP_LSL: begin res = {opd_a[MSB-1:0], 1'b0}; c_n = opd_a[MSB]; upd = 1'b1; shv = 1'b1; end
      OP_ROL: begin res = {opd_a[MSB-1:0], cin};  c_n = opd_a[MSB]; upd = 1'b1; shv = 1'b1; end
      OP_LSR: begin res = {1'b0, opd_a[MSB:1]};   c_n = opd_a[0];   upd = 1'b1; shv = 1'b1; end
      OP_ROR: begin res = {cin, opd_a[MSB:1]};    c_n = opd_a[0];   upd = 1'b1; shv = 1'b1; end
      OP_ASR: begin res = {opd_a[MSB], opd_a[MSB:1]}; c_n = opd_a[0]; upd = 1'b1; shv = 1'b1; end
      OP_SWP: res = {opd_a[HB-1:0], opd_a[MSB:HB]};
      OP_BST: t_n = opd_a[bit_idx];
      OP_BLD: res[bit_idx] = flg_q[FT];
      default: ;
    endcase
    n_n = upd ? res[MSB] : flg_q[FN];
    if (shv) v_n = n_n ^ c_n;
    if (!upd)          z_n = flg_q[FZ];
    else if (chain_op) z_n = flg_q[FZ] & ~|res;
    else               z_n = ~|res;
    s_n = upd ? (n_n ^ v_n) : flg_q[FS];
    nxt = {flg_q[FI], t_n, h_n, s_n, v_n, n_n, z_n, c_n};
    if (op == OP_FSET) nxt[bit_idx] = 1'b1;
    if (op == OP_FCLR) nxt[bit_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flg_q <= 8'h00;
    else if (exec) flg_q <= nxt;
  end

  assign result     = res;
  assign flags_next = nxt;
  assign flags      = flg_q;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       exec,
  input logic [4:0] op,
  input logic [2:0] bit_idx,
  input logic [7:0] flags
);
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> flags == $past(flags));

  // R4
  logic_keeps_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec && (op == 5'd6 || op == 5'd7 || op == 5'd8) |=>
      flags[0] == $past(flags[0]) && flags[5] == $past(flags[5]) && !flags[3]);

  // R3
  chained_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec && (op == 5'd3 || op == 5'd5) && !flags[1] |=> !flags[1]);

  // R6
  com_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == 5'd9 |=> flags[0] && !flags[3]);

  // R8
  swap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == 5'd18 |=> flags == $past(flags));

  // R9
  signed_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op <= 5'd17 |=> flags[4] == (flags[2] ^ flags[3]));

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == 5'd19 |=> flags[$past(bit_idx)]);

  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == 5'd20 |=> !flags[$past(bit_idx)]);
endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .bit_idx(bit_idx), .flags(flags)
);

// File: tb/alu8_flags_test.sv
module alu8_flags_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] opd_a = '0, opd_b = '0;
  logic [2:0] bit_idx = '0;
  logic [7:0] result, flags_next, flags;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] mflags = 8'h00;

  always #4 clk = ~clk;

  alu8_flags uut (
    .clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .opd_a(opd_a), .opd_b(opd_b),
    .bit_idx(bit_idx), .result(result), .flags_next(flags_next), .flags(flags)
  );

  function automatic string req_of(input int o);
    case (o)
      0, 1, 2, 4: return "R1/R2";
      3, 5:       return "R3";
      6, 7, 8:    return "R4";
      9, 10:      return "R6";
      11, 12:     return "R5";
      13, 14, 15, 16, 17: return "R7";
      18:         return "R8";
      19, 20, 21, 22: return "R10";
      default:    return "R11";
    endcase
  endfunction

  function automatic int sgn(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  task automatic model(input int o, input int a, input int b, input int bi,
                       input logic [7:0] f, output int r, output logic [7:0] nf);
    int ci, t;
    bit upd, keepz, shift;
    logic c, z, n, v, s, h, tt;
    c = f[0]; z = f[1]; n = f[2]; v = f[3]; s = f[4]; h = f[5]; tt = f[6];
    r = a; upd = 0; keepz = 0; shift = 0;
    case (o)
      0, 1: begin
        ci = (o == 1) ? int'(f[0]) : 0;
        t = a + b + ci; r = t % 256; c = (t > 255);
        h = ((a % 16) + (b % 16) + ci) > 15;
        t = sgn(a) + sgn(b) + ci; v = (t > 127 || t < -128); upd = 1;
      end
      2, 3, 4, 5: begin
        ci = (o == 3 || o == 5) ? int'(f[0]) : 0;
        t = a - b - ci; r = (t + 512) % 256; c = (t < 0);
        h = ((a % 16) - (b % 16) - ci) < 0;
        t = sgn(a) - sgn(b) - ci; v = (t > 127 || t < -128); upd = 1;
        keepz = (o == 3 || o == 5);
      end
      6: begin r = a & b; v = 0; upd = 1; end
      7: begin r = a | b; v = 0; upd = 1; end
      8: begin r = a ^ b; v = 0; upd = 1; end
      9: begin r = 255 - a; c = 1; v = 0; upd = 1; end
      10: begin r = (256 - a) % 256; c = (a != 0); h = (a % 16) != 0; v = (a == 128); upd = 1; end
      11: begin r = (a + 1) % 256; v = (a == 127); upd = 1; end
      12: begin r = (a + 255) % 256; v = (a == 128); upd = 1; end
      13: begin r = (a * 2) % 256; c = (a >= 128); upd = 1; shift = 1; end
      15: begin r = (a * 2 + int'(f[0])) % 256; c = (a >= 128); upd = 1; shift = 1; end
      14: begin r = a / 2; c = a % 2; upd = 1; shift = 1; end
      16: begin r = a / 2 + int'(f[0]) * 128; c = a % 2; upd = 1; shift = 1; end
      17: begin r = a / 2 + (a / 128) * 128; c = a % 2; upd = 1; shift = 1; end
      18: r = (a % 16) * 16 + a / 16;
      21: tt = ((a >> bi) & 1) != 0;
      22: r = f[6] ? (a | (1 << bi)) : (a & ~(1 << bi) & 255);
      default: ;
    endcase
    if (upd) begin
      n = (r >= 128);
      if (shift) v = n ^ c;
      z = keepz ? (z && r == 0) : (r == 0);
      s = n ^ v;
    end
    nf = {f[7], tt, h, s, v, n, z, c};
    if (o == 19) nf[bi] = 1'b1;
    if (o == 20) nf[bi] = 1'b0;
  endtask

  task automatic check(input bit ok, input string req, input string what, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step(input int o, input int a, input int b, input int bi, input bit ex);
    int r;
    logic [7:0] nf;
    @(negedge clk);
    op = o[4:0]; opd_a = a[7:0]; opd_b = b[7:0]; bit_idx = bi[2:0]; exec = ex;
    model(o, a, b, bi, mflags, r, nf);
    #1;
    // R13: result and flags_next settle in the same cycle
    check(result == r[7:0], req_of(o), $sformatf("result op=%0d a=%h b=%h", o, a, b), result, r);
    check(flags_next == nf, "R13", $sformatf("flags_next op=%0d a=%h b=%h", o, a, b), flags_next, nf);
    @(posedge clk);
    #1;
    if (ex) mflags = nf;
    // R12: commit only with exec
    check(flags == mflags, ex ? req_of(o) : "R12",
          $sformatf("flags op=%0d a=%h b=%h ex=%0d", o, a, b, ex), flags, mflags);
  endtask

  task automatic preload(input logic [7:0] w);
    for (int i = 0; i < 8; i++) step(w[i] ? 19 : 20, 8'h5A, 0, i, 1'b1);
  endtask

  initial begin
    int corners[4];
    int ops[21];
    corners = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    for (int i = 0; i < 19; i++) ops[i] = i;
    ops[19] = 21; ops[20] = 22;

    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    check(flags == 8'h00, "R12", "flags after reset", flags, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R12: exec low keeps flags
    step(19, 0, 0, 0, 1'b0);
    step(0, 8'hFF, 8'h01, 0, 1'b0);

    for (int k = 0; k < 21; k++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int c = 0; c < 2; c++) begin
            logic [7:0] w;
            w = 8'($urandom_range(255));
            w[0] = c[0];
            preload(w);
            step(ops[k], corners[i], corners[j], (i * 4 + j + c) % 8, 1'b1);
          end

    // R3: chained compare across two bytes, low bytes equal then high bytes differ
    preload(8'h00);
    step(4, 8'h34, 8'h34, 0, 1'b1);
    step(5, 8'h12, 8'h12, 0, 1'b1);
    step(5, 8'h12, 8'h13, 0, 1'b1);

    for (int n = 0; n < 3000; n++)
      step($urandom_range(31), $urandom_range(255), $urandom_range(255),
           $urandom_range(7), $urandom_range(9) != 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule